// File: doc/BRIEF.md
# Smart Card Receive Status Checker

This block sits between a character-level smart card receiver and the host. Every byte the receiver delivers goes into a small receive FIFO that the host drains through a pop port. Alongside the FIFO the block keeps one control/status register. It holds the FIFO fill flags, the sticky error flags and the ninth data bit of synchronous 9-bit transfers. It also holds a last-byte flag, which the host sets while the final byte of a block is still on its way.

Each incoming block is folded into a check accumulator. With `cfg_crc` high this is a CRC-16 (polynomial 0x1021, MSB first). With it low this is a longitudinal XOR. When a byte is taken in while the last-byte flag is set, the block closes. The CRC must then equal the fixed constant 0x1D0F, or the XOR must be zero. A mismatch raises the check-error flag. The accumulator then starts again for the next block.

An overrun puts the block into a lockout. The lockout discards further bytes, drops the open block and holds until the host reads the status register. A three-state controller covers the whole receive side. ST_RUN is normal reception. ST_ARMED means the last-byte flag is set. ST_LOCKED means overrun lockout. Its transitions are:
- T_ARM: from ST_RUN to ST_ARMED, on a host write of 1 to the last flag.
- T_CLOSE: from ST_ARMED to ST_RUN, when a byte is accepted.
- T_DISARM: from ST_ARMED to ST_RUN, on a host write of 0.
- T_OVERRUN: from ST_RUN or ST_ARMED to ST_LOCKED, when a byte arrives with the FIFO full.
- T_UNLOCK: from ST_LOCKED to ST_RUN, on a status read.

Top module: `sc_rx_status`

## Requirements
- R1: After reset, the status reads 0x04 (only FIFO-empty set), the FIFO holds nothing and `irq_rxerr` is low.
- R2: A byte arriving while the FIFO is not full and no overrun is pending is stored. Pops return stored bytes in arrival order on `pop_data`. Status bit 3 (full) is set when DEPTH bytes are held. Status bit 2 (empty) is set when none are held. The two are never set together.
- R3: A byte arriving while the FIFO is full sets status bit 1 (overrun) and is discarded. Every further byte is discarded, and FIFO contents stay unchanged, until the host reads the status register.
- R4: Entering overrun drops the open block: the last-byte flag clears and the check accumulators return to their start values.
- R5: A byte arriving with `rx_perr` high sets status bit 0 (parity error). The byte is still stored if R2 allows it.
- R6: A host read (`host_rd`) clears status bits 0, 1 and 4 in the next cycle. A flag being set in the same cycle as the read stays set.
- R7: Status bit 5 (last byte) is set or cleared by a host write of `host_wlast`. The write is ignored during overrun. The flag clears itself on the cycle after the byte that closes the block. An arriving byte takes priority over a simultaneous write.
- R8: With `cfg_crc`=1, accepted bytes feed a CRC-16 (poly 0x1021, MSB first, start value CRC_INIT, default 0xFFFF). If the value after the closing byte differs from 0x1D0F, status bit 4 (check error) is set.
- R9: With `cfg_crc`=0, accepted bytes are XORed together. If the XOR after the closing byte is non-zero, status bit 4 is set.
- R10: After a block closes, the accumulators restart from their start values, so a second block is checked independently of the first.
- R11: With `cfg_sync9`=1, each stored byte copies `rx_bit9` into status bit 7. With `cfg_sync9`=0, bit 7 holds its value. Bit 6 always reads 0.
- R12: `irq_rxerr` is high exactly while status bit 0 or bit 1 is set. The empty flag and the check-error flag do not raise it.
- R13: A pop while the FIFO is empty is ignored. A byte stored and a byte popped in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error reported with this byte |
| rx_bit9 | input | 1 | IO level sampled on the ninth clock edge |
| cfg_crc | input | 1 | 1 = CRC-16 check, 0 = XOR check |
| cfg_sync9 | input | 1 | Synchronous 9-bit format enabled |
| host_wr | input | 1 | Host write strobe to the status register |
| host_wlast | input | 1 | Value written to the last-byte flag |
| host_rd | input | 1 | Host read strobe (clears error flags) |
| host_rdata | output | 8 | Status register contents |
| pop | input | 1 | Remove the head byte from the FIFO |
| pop_data | output | 8 | Head byte of the FIFO |
| irq_rxerr | output | 1 | Receive-error interrupt |

## Verification
The bound checker watches several rules on every cycle. Full and empty never coincide. A byte arriving into a full FIFO always raises overrun. An accepted byte always drops the armed last-byte flag. A read with no arrival always leaves the error flags clear, and a pop on an empty FIFO changes nothing. It also checks that bit 7 is frozen outside 9-bit mode and that the interrupt tracks the two error flags. Other behaviour only the bench scenarios can show. This covers the byte ordering through the FIFO and the discarding of bytes during lockout. It also covers the abandoning of an armed block on overrun, the CRC and XOR verdicts on good and corrupted blocks, and the restart of the accumulator between blocks.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } rx_state_e;

    localparam int BIT_NINTH  = 7;
    localparam int BIT_LAST   = 5;
    localparam int BIT_CHKERR = 4;
    localparam int BIT_FULL   = 3;
    localparam int BIT_EMPTY  = 2;
    localparam int BIT_OVR    = 1;
    localparam int BIT_PERR   = 0;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                               input logic [7:0]  d,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ poly;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sc_rx_check.sv
module sc_rx_check
    import sc_rx_pkg::*;
#(
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF,
    parameter logic [15:0] CRC_GOOD = 16'h1D0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       crc_mode,
    input  logic       take,
    input  logic [7:0] data,
    input  logic       close,
    input  logic       restart,
    output logic       mismatch
);
    logic [15:0] crc_q, crc_nxt;
    logic [7:0]  lrc_q, lrc_nxt;

    assign crc_nxt  = crc16_step(crc_q, data, CRC_POLY);
    assign lrc_nxt  = lrc_q ^ data;
    assign mismatch = crc_mode ? (crc_nxt != CRC_GOOD) : (lrc_nxt != 8'h00);

    always_ff @(posedge clk) begin
        if (!rst_n || close || restart) begin
            crc_q <= CRC_INIT;
            lrc_q <= 8'h00;
        end else if (take) begin
            crc_q <= crc_nxt;
            lrc_q <= lrc_nxt;
        end
    end
endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
    import sc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic fifo_full,
    input  logic host_wr,
    input  logic host_wlast,
    input  logic host_rd,
    output logic accept,
    output logic close,
    output logic abandon,
    output logic last_flag,
    output logic ovr_flag
);
    rx_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (arrive && fifo_full)     nxt = ST_LOCKED;
                else if (host_wr && host_wlast) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (arrive && fifo_full)      nxt = ST_LOCKED;
                else if (arrive)              nxt = ST_RUN;
                else if (host_wr && !host_wlast) nxt = ST_RUN;
            end
            ST_LOCKED: begin
                if (host_rd) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        accept    = arrive && !fifo_full && (state != ST_LOCKED);
        close     = accept && (state == ST_ARMED);
        abandon   = arrive && fifo_full && (state != ST_LOCKED);
        last_flag = (state == ST_ARMED);
        ovr_flag  = (state == ST_LOCKED);
    end
endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status
    import sc_rx_pkg::*;
#(
    parameter int          DEPTH    = 4,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_bit9,
    input  logic       cfg_crc,
    input  logic       cfg_sync9,
    input  logic       host_wr,
    input  logic       host_wlast,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    input  logic       pop,
    output logic [7:0] pop_data,
    output logic       irq_rxerr
);
    logic accept, close, abandon, last_flag, ovr_flag;
    logic full, empty, mismatch;
    logic perr_q, chkerr_q, ninth_q;

    sc_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arrive     (rx_valid),
        .fifo_full  (full),
        .host_wr    (host_wr),
        .host_wlast (host_wlast),
        .host_rd    (host_rd),
        .accept     (accept),
        .close      (close),
        .abandon    (abandon),
        .last_flag  (last_flag),
        .ovr_flag   (ovr_flag)
    );

    sc_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (rx_data),
        .pop       (pop),
        .head      (pop_data),
        .full      (full),
        .empty     (empty)
    );

    sc_rx_check #(.CRC_INIT(CRC_INIT)) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .crc_mode (cfg_crc),
        .take     (accept),
        .data     (rx_data),
        .close    (close),
        .restart  (abandon),
        .mismatch (mismatch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q   <= 1'b0;
            chkerr_q <= 1'b0;
            ninth_q  <= 1'b0;
        end else begin
            if (rx_valid && rx_perr) perr_q <= 1'b1;
            else if (host_rd)        perr_q <= 1'b0;
            if (close && mismatch)   chkerr_q <= 1'b1;
            else if (host_rd)        chkerr_q <= 1'b0;
            if (accept && cfg_sync9) ninth_q <= rx_bit9;
        end
    end

    always_comb begin
        host_rdata             = 8'h00;
        host_rdata[BIT_NINTH]  = ninth_q;
        host_rdata[BIT_LAST]   = last_flag;
        host_rdata[BIT_CHKERR] = chkerr_q;
        host_rdata[BIT_FULL]   = full;
        host_rdata[BIT_EMPTY]  = empty;
        host_rdata[BIT_OVR]    = ovr_flag;
        host_rdata[BIT_PERR]   = perr_q;
        irq_rxerr              = perr_q || ovr_flag;
    end
endmodule

// File: rtl/sc_rx_status_chk.sv
module sc_rx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       host_rd,
    input logic       pop,
    input logic       cfg_sync9,
    input logic [7:0] host_rdata,
    input logic       irq_rxerr
);
    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rdata[3] && host_rdata[2]));

    assert_overrun_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[3] && rx_valid && !host_rdata[1]) |=> host_rdata[1]);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rx_valid) |=> (host_rdata[1:0] == 2'b00 && !host_rdata[4]));

    assert_last_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[5] && rx_valid && !host_rdata[3]) |=> !host_rdata[5]);

    assert_ninth_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sync9 |=> $stable(host_rdata[7]));

    assert_irq_on_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[1:0] != 2'b00) |-> irq_rxerr);

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[1:0] == 2'b00) |-> !irq_rxerr);

    assert_empty_pop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[2] && pop && !rx_valid) |=> host_rdata[2]);
endmodule

bind sc_rx_status sc_rx_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .host_rd    (host_rd),
    .pop        (pop),
    .cfg_sync9  (cfg_sync9),
    .host_rdata (host_rdata),
    .irq_rxerr  (irq_rxerr)
);

// File: tb/sc_rx_status_tb.sv
module sc_rx_status_tb;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_bit9 = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       cfg_crc = 1'b0, cfg_sync9 = 1'b0;
    logic       host_wr = 1'b0, host_wlast = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata, pop_data;
    logic       pop = 1'b0, irq_rxerr;

    int   n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q [$];
    logic [7:0] rv;

    always #4 clk = ~clk;

    sc_rx_status #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_bit9(rx_bit9), .cfg_crc(cfg_crc),
        .cfg_sync9(cfg_sync9), .host_wr(host_wr), .host_wlast(host_wlast),
        .host_rd(host_rd), .host_rdata(host_rdata), .pop(pop),
        .pop_data(pop_data), .irq_rxerr(irq_rxerr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic stat_is(input logic [7:0] mask, input logic [7:0] exp, input string req);
        check((host_rdata & mask) == exp, req, host_rdata & mask, exp);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // driver: pushes the expected byte into the scoreboard when it should be stored
    task automatic send(input logic [7:0] d, input bit perr, input bit b9, input bit keep);
        rx_valid = 1'b1; rx_data = d; rx_perr = perr; rx_bit9 = b9;
        step();
        rx_valid = 1'b0; rx_perr = 1'b0;
        if (keep) exp_q.push_back(d);
    endtask

    task automatic wr_last(input bit v);
        host_wr = 1'b1; host_wlast = v;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        host_rd = 1'b1;
        v = host_rdata;
        step();
        host_rd = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = exp_q.size();
        for (int i = 0; i < n; i++) begin
            pop = 1'b1;
            step();
            pop = 1'b0;
        end
    endtask

    // monitor: compares the head byte against the scoreboard on each pop
    always @(negedge clk) begin
        if (pop && exp_q.size() > 0) begin
            check(pop_data == exp_q[0], "R2 fifo order", pop_data, exp_q[0]);
            void'(exp_q.pop_front());
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            logic top;
            top = r[15] ^ d[7 - b];
            r = r << 1;
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [15:0] find_tail();
        logic [15:0] base;
        base = ref_crc(ref_crc(16'hFFFF, 8'h31), 8'h32);
        for (int v = 0; v < 65536; v++) begin
            logic [15:0] t;
            t = v[15:0];
            if (ref_crc(ref_crc(base, t[15:8]), t[7:0]) == 16'h1D0F) return t;
        end
        return 16'h0000;
    endfunction

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] tail;
        tail = find_tail();
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check(host_rdata == 8'h04, "R1 reset status", host_rdata, 8'h04);
        check(irq_rxerr == 1'b0, "R1 reset irq", irq_rxerr, 0);

        // R13 pop on empty ignored
        pop = 1'b1; step(); pop = 1'b0;
        stat_is(8'h0C, 8'h04, "R13 pop on empty");

        // R2 basic ordering
        send(8'h11, 0, 0, 1); send(8'h22, 0, 0, 1); send(8'h33, 0, 0, 1);
        stat_is(8'h0C, 8'h00, "R2 partial fill");
        drain();
        stat_is(8'h0C, 8'h04, "R2 empty after drain");

        // R2/R3/R4/R7 fill, arm, overrun
        send(8'hA1, 0, 0, 1); send(8'hA2, 0, 0, 1); send(8'hA3, 0, 0, 1); send(8'hA4, 0, 0, 1);
        stat_is(8'h0C, 8'h08, "R2 full at depth");
        wr_last(1'b1);
        stat_is(8'h20, 8'h20, "R7 last flag set by write");
        send(8'hEE, 0, 0, 0);
        stat_is(8'h22, 8'h02, "R3 overrun set, R4 last cleared");
        check(irq_rxerr == 1'b1, "R12 irq on overrun", irq_rxerr, 1);
        pop = 1'b1; step(); pop = 1'b0;   // free a slot while locked
        send(8'hEF, 0, 0, 0);
        stat_is(8'h0E, 8'h02, "R3 byte discarded during lockout");
        wr_last(1'b1);
        rd_stat(rv);
        check(rv[5] == 1'b0, "R7 write ignored during lockout", rv[5], 0);
        check(rv[1] == 1'b1, "R3 overrun visible at read", rv[1], 1);
        check(host_rdata[1] == 1'b0 && irq_rxerr == 1'b0, "R6 overrun cleared by read", host_rdata, 0);
        drain();

        // R4/R9 XOR block after abandon: accumulator restarted
        cfg_crc = 1'b0;
        send(8'h5A, 0, 0, 1);
        wr_last(1'b1);
        send(8'h5A, 0, 0, 1);
        stat_is(8'h30, 8'h00, "R9 XOR good, R4 restart after abandon");
        send(8'h0F, 0, 0, 1);
        wr_last(1'b1);
        send(8'hF0, 0, 0, 1);
        stat_is(8'h30, 8'h10, "R9 XOR nonzero gives check error");
        check(irq_rxerr == 1'b0, "R12 check error raises no irq", irq_rxerr, 0);
        drain();
        rd_stat(rv);
        stat_is(8'h10, 8'h00, "R6 check error cleared by read");

        // R7 write 0 disarms
        wr_last(1'b1);
        wr_last(1'b0);
        stat_is(8'h20, 8'h00, "R7 write zero clears last flag");

        // R8/R10 CRC blocks
        cfg_crc = 1'b1;
        for (int k = 0; k < 2; k++) begin
            send(8'h31, 0, 0, 1); send(8'h32, 0, 0, 1); send(tail[15:8], 0, 0, 1);
            wr_last(1'b1);
            send(tail[7:0], 0, 0, 1);
            stat_is(8'h30, 8'h00, k == 0 ? "R8 CRC good block" : "R10 second CRC block restarts");
            drain();
        end
        send(8'h31, 0, 0, 1); send(8'h32, 0, 0, 1); send(tail[15:8], 0, 0, 1);
        wr_last(1'b1);
        send(tail[7:0] ^ 8'h01, 0, 0, 1);
        stat_is(8'h30, 8'h10, "R8 CRC corrupted block");
        drain();
        rd_stat(rv);

        // R5/R12 parity
        send(8'h77, 1, 0, 1);
        stat_is(8'h07, 8'h01, "R5 parity flag and byte stored");
        check(irq_rxerr == 1'b1, "R12 irq on parity", irq_rxerr, 1);
        // R6 set wins over simultaneous read
        host_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h78; rx_perr = 1'b1;
        step();
        host_rd = 1'b0; rx_valid = 1'b0; rx_perr = 1'b0;
        exp_q.push_back(8'h78);
        stat_is(8'h01, 8'h01, "R6 set wins over read");
        rd_stat(rv);
        stat_is(8'h01, 8'h00, "R6 parity cleared by read");
        drain();

        // R11 ninth bit
        cfg_sync9 = 1'b1;
        send(8'h01, 0, 1, 1);
        stat_is(8'h80, 8'h80, "R11 ninth bit captured");
        cfg_sync9 = 1'b0;
        send(8'h02, 0, 0, 1);
        stat_is(8'hC0, 8'h80, "R11 ninth bit held outside 9-bit mode");
        cfg_sync9 = 1'b1;
        send(8'h03, 0, 0, 1);
        stat_is(8'h80, 8'h00, "R11 ninth bit recaptured");
        cfg_sync9 = 1'b0;
        drain();

        // R13 simultaneous push and pop
        send(8'h41, 0, 0, 1);
        pop = 1'b1; rx_valid = 1'b1; rx_data = 8'h42;
        step();
        pop = 1'b0; rx_valid = 1'b0;
        exp_q.push_back(8'h42);
        stat_is(8'h0C, 8'h00, "R13 push and pop keep level");
        pop = 1'b1; step(); pop = 1'b0;
        stat_is(8'h0C, 8'h04, "R13 one byte remained");
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule